// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Channel

This block sequences one audio DMA unit with two independent directions: a transmit side that fetches playback samples from memory and a receive side that stores recorded samples into memory. For each direction, software writes a word-aligned buffer base address and a byte length, then sets that direction's enable bit in a shared control register. The direction then issues one memory request per 4-byte word. Each request holds its address until the memory side acknowledges it, and each accepted beat moves the address and the in-pass byte count forward by 4.

Two event pulses per direction mark the ring. One fires as the pass crosses half the programmed length and one fires when the pass completes. When auto-reload is set, the direction wraps to its base address and keeps running, so the two halves act as a ping-pong pair that software refills in turn. Without auto-reload, the direction drops its enable after the completion event and goes idle. A stop bit in the control register ends a direction at once.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset every readable register returns 0, both request outputs are low, and all four event bits are low.
- R2: The register offsets are 0x00 transmit base, 0x04 receive base, 0x08 transmit length, 0x0C receive length, 0x10 control, 0x14 transmit progress and 0x18 receive progress. Base and length registers read back with bits 1:0 forced to zero. Length registers keep only bits 25:2, so the largest length is 0x03FFFFFC. Any unmapped offset reads 0.
- R3: The control register holds one field group per direction. Transmit uses bit 0 enable, bit 1 stop, bit 2 auto-reload and bits 9:8 alignment. Receive uses the same layout shifted up by 16 (bits 16, 17, 18 and 25:24). The enable bit reads back as whether the direction is running, the stop bits always read 0, and auto-reload and alignment read back as written.
- R4: Writing 1 to the enable bit of an idle direction, with its stop bit at 0, starts it. From the next cycle the request is high, the address equals the base, and the progress register reads 0.
- R5: While a request is high and unacknowledged, its address holds. Each cycle with both request and acknowledge high adds 4 to the address and to the progress register.
- R6: A one-cycle pulse on event bit 0 (transmit) or bit 2 (receive) appears in the cycle after the beat that takes progress from below length/2 to length/2 or above, unless that beat also ends the pass.
- R7: A one-cycle pulse on event bit 1 (transmit) or bit 3 (receive) appears in the cycle after the beat that takes progress to the length or above. That beat resets progress to 0 and the address to the base.
- R8: With auto-reload set, the direction keeps requesting after a completed pass and starts again from the base address.
- R9: With auto-reload clear, the request drops and the enable bit reads 0 from the cycle after the completing beat.
- R10: Writing 1 to a stop bit makes that direction idle from the next cycle, with progress 0 and no event, even if an enable bit is written in the same write or a beat is acknowledged on the same edge.
- R11: The two directions run independently. A beat, event or stop on one leaves the other's request, address, progress and events unchanged.
- R12: Writing enable to a direction that is already running does not restart it: its address and progress carry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| tx_req | output | 1 | Transmit memory read request |
| tx_addr | output | 32 | Transmit beat address |
| tx_ack | input | 1 | Transmit beat accepted |
| rx_req | output | 1 | Receive memory write request |
| rx_addr | output | 32 | Receive beat address |
| rx_ack | input | 1 | Receive beat accepted |
| evt | output | 4 | Events: 0 tx half, 1 tx full, 2 rx half, 3 rx full |

## Verification
Register reads are combinational, so a read is due in the same cycle as the address that selects it. The bench drives inputs on the falling edge and checks read data one time unit later. Requests, addresses, progress and events are all registered, so each is due in the cycle after the write or the acknowledged beat that causes it. The bench checks them on the next falling edge against a model that it advances exactly once per clock. The model applies the same priority the requirements give: stop first, then start, then a beat. It evaluates a beat with the register values from before any write on that same edge.

// File: rtl/ardma_pkg.sv
package ardma_pkg;
    localparam int NDIR       = 2;
    localparam int REG_AW     = 5;
    localparam int DIR_STRIDE = 16;
    localparam int CB_EN      = 0;
    localparam int CB_STOP    = 1;
    localparam int CB_AUTO    = 2;
    localparam int CB_ALIGN   = 8;

    typedef enum logic [REG_AW-1:0] {
        OFS_TX_BASE = 5'h00,
        OFS_RX_BASE = 5'h04,
        OFS_TX_LEN  = 5'h08,
        OFS_RX_LEN  = 5'h0C,
        OFS_CTRL    = 5'h10,
        OFS_TX_CUR  = 5'h14,
        OFS_RX_CUR  = 5'h18
    } reg_ofs_e;
endpackage

// File: rtl/ring_dir_seq.sv
module ring_dir_seq #(
    parameter int AW   = 32,
    parameter int CW   = 26,
    parameter int BEAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          auto_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] len_i,
    input  logic          ack_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] cnt_o,
    output logic          half_o,
    output logic          full_o
);
    localparam int SW = CW + 1;

    typedef struct packed {
        logic          active;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          half;
        logic          full;
    } st_t;

    st_t           q, d;
    logic [SW-1:0] nxt;
    logic [CW-1:0] mid;
    logic          beat;

    always_comb begin
        d      = q;
        d.half = 1'b0;
        d.full = 1'b0;
        beat   = q.active && ack_i;
        nxt    = {1'b0, q.cnt} + SW'(BEAT);
        mid    = len_i >> 1;
        if (stop_i) begin
            d.active = 1'b0;
            d.cnt    = '0;
        end else if (start_i && !q.active) begin
            d.active = 1'b1;
            d.addr   = base_i;
            d.cnt    = '0;
        end else if (beat) begin
            if (nxt >= {1'b0, len_i}) begin
                d.full   = 1'b1;
                d.cnt    = '0;
                d.addr   = base_i;
                d.active = auto_i;
            end else begin
                d.half = (q.cnt < mid) && (nxt >= {1'b0, mid});
                d.cnt  = nxt[CW-1:0];
                d.addr = q.addr + AW'(BEAT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_o  = q.active;
    assign addr_o = q.addr;
    assign cnt_o  = q.cnt;
    assign half_o = q.half;
    assign full_o = q.full;

    AST_EVT_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (half_o || full_o) |-> $past(req_o && ack_i)); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && !stop_i) |=> $stable(addr_o)); // R5
    AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!req_o && !half_o && !full_o)); // R10
    AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (cnt_o == '0 && addr_o == $past(base_i))); // R7
    AST_NOAUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !$past(auto_i)) |-> !req_o); // R9
endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma #(
    parameter int CW = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_req,
    output logic [31:0] tx_addr,
    input  logic        tx_ack,
    output logic        rx_req,
    output logic [31:0] rx_addr,
    input  logic        rx_ack,
    output logic [3:0]  evt
);
    import ardma_pkg::*;

    localparam int AW = 32;

    typedef struct packed {
        logic [NDIR-1:0][AW-1:0] base;
        logic [NDIR-1:0][CW-1:0] len;
        logic [NDIR-1:0]         autor;
        logic [NDIR-1:0][1:0]    align;
    } regs_t;

    regs_t                   q, d;
    logic [NDIR-1:0]         start_w, stop_w, req_w, half_w, full_w, ack_w;
    logic [NDIR-1:0][AW-1:0] addr_w;
    logic [NDIR-1:0][CW-1:0] cnt_w;

    assign ack_w = {rx_ack, tx_ack};

    always_comb begin
        d       = q;
        start_w = '0;
        stop_w  = '0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_TX_BASE: d.base[0] = {reg_wdata[31:2], 2'b00};
                OFS_RX_BASE: d.base[1] = {reg_wdata[31:2], 2'b00};
                OFS_TX_LEN:  d.len[0]  = {reg_wdata[CW-1:2], 2'b00};
                OFS_RX_LEN:  d.len[1]  = {reg_wdata[CW-1:2], 2'b00};
                OFS_CTRL: begin
                    for (int i = 0; i < NDIR; i++) begin
                        start_w[i]  = reg_wdata[i*DIR_STRIDE+CB_EN];
                        stop_w[i]   = reg_wdata[i*DIR_STRIDE+CB_STOP];
                        d.autor[i]  = reg_wdata[i*DIR_STRIDE+CB_AUTO];
                        d.align[i]  = reg_wdata[i*DIR_STRIDE+CB_ALIGN +: 2];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_TX_BASE: reg_rdata = q.base[0];
            OFS_RX_BASE: reg_rdata = q.base[1];
            OFS_TX_LEN:  reg_rdata = 32'(q.len[0]);
            OFS_RX_LEN:  reg_rdata = 32'(q.len[1]);
            OFS_TX_CUR:  reg_rdata = 32'(cnt_w[0]);
            OFS_RX_CUR:  reg_rdata = 32'(cnt_w[1]);
            OFS_CTRL: begin
                for (int i = 0; i < NDIR; i++) begin
                    reg_rdata[i*DIR_STRIDE+CB_EN]         = req_w[i];
                    reg_rdata[i*DIR_STRIDE+CB_AUTO]       = q.autor[i];
                    reg_rdata[i*DIR_STRIDE+CB_ALIGN +: 2] = q.align[i];
                end
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        ring_dir_seq #(.AW(AW), .CW(CW), .BEAT(4)) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_w[g]),
            .stop_i  (stop_w[g]),
            .auto_i  (q.autor[g]),
            .base_i  (q.base[g]),
            .len_i   (q.len[g]),
            .ack_i   (ack_w[g]),
            .req_o   (req_w[g]),
            .addr_o  (addr_w[g]),
            .cnt_o   (cnt_w[g]),
            .half_o  (half_w[g]),
            .full_o  (full_w[g])
        );
        assign evt[2*g]   = half_w[g];
        assign evt[2*g+1] = full_w[g];
    end

    assign tx_req  = req_w[0];
    assign rx_req  = req_w[1];
    assign tx_addr = addr_w[0];
    assign rx_addr = addr_w[1];

    AST_LEN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.len[0][1:0] == 2'b00) && (q.len[1][1:0] == 2'b00)); // R2
endmodule

// File: tb/test_audio_ring_dma.sv
module test_audio_ring_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_req, rx_req, tx_ack = 1'b0, rx_ack = 1'b0;
    logic [31:0] tx_addr, rx_addr;
    logic [3:0]  evt;

    int nchk = 0, nfail = 0, cyc = 0;
    string tag = "R1";

    // model state
    bit          m_act[2], m_half[2], m_full[2], m_auto[2];
    logic [31:0] m_addr[2], m_cnt[2], m_base[2], m_len[2];
    logic [1:0]  m_align[2];

    always #10 clk = ~clk;

    audio_ring_dma i_audio_ring_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
        .tx_addr(tx_addr), .tx_ack(tx_ack), .rx_req(rx_req),
        .rx_addr(rx_addr), .rx_ack(rx_ack), .evt(evt)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        logic [31:0] r = '0;
        case (a)
            5'h00: r = m_base[0];
            5'h04: r = m_base[1];
            5'h08: r = m_len[0];
            5'h0C: r = m_len[1];
            5'h14: r = m_cnt[0];
            5'h18: r = m_cnt[1];
            5'h10: for (int i = 0; i < 2; i++) begin
                r[i*16]      = m_act[i];
                r[i*16+2]    = m_auto[i];
                r[i*16+8 +: 2] = m_align[i];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // one clock: check outputs, drive, check read, advance model
    task automatic step(input bit wr, input logic [4:0] a, input logic [31:0] wd, input bit k0, input bit k1);
        logic [31:0] n;
        bit ack[2];
        chk(tx_req === m_act[0], "R4 tx_req", 32'(tx_req), 32'(m_act[0]));
        chk(rx_req === m_act[1], "R4 rx_req", 32'(rx_req), 32'(m_act[1]));
        if (m_act[0]) chk(tx_addr === m_addr[0], "R5 tx_addr", tx_addr, m_addr[0]);
        if (m_act[1]) chk(rx_addr === m_addr[1], "R5 rx_addr", rx_addr, m_addr[1]);
        chk(evt === {m_full[1], m_half[1], m_full[0], m_half[0]}, "R6/R7 evt",
            32'(evt), 32'({m_full[1], m_half[1], m_full[0], m_half[0]}));
        reg_wr = wr; reg_addr = a; reg_wdata = wd; tx_ack = k0; rx_ack = k1;
        ack[0] = k0; ack[1] = k1;
        #1;
        if (!wr) chk(reg_rdata === exp_read(a), (a == 5'h10) ? "R3 ctrl read" : "R2 reg read",
                     reg_rdata, exp_read(a));
        for (int i = 0; i < 2; i++) begin
            bit st = wr && a == 5'h10 && wd[i*16+1];
            bit go = wr && a == 5'h10 && wd[i*16];
            m_half[i] = 0; m_full[i] = 0;
            if (st) begin
                m_act[i] = 0; m_cnt[i] = 0;
            end else if (go && !m_act[i]) begin
                m_act[i] = 1; m_addr[i] = m_base[i]; m_cnt[i] = 0;
            end else if (m_act[i] && ack[i]) begin
                n = m_cnt[i] + 4;
                if (n >= m_len[i]) begin
                    m_full[i] = 1; m_cnt[i] = 0; m_addr[i] = m_base[i]; m_act[i] = m_auto[i];
                end else begin
                    m_half[i] = (m_cnt[i] < (m_len[i] >> 1)) && (n >= (m_len[i] >> 1));
                    m_cnt[i] = n; m_addr[i] = m_addr[i] + 4;
                end
            end
            if (wr && a == 5'h10) begin
                m_auto[i] = wd[i*16+2]; m_align[i] = wd[i*16+8 +: 2];
            end
        end
        if (wr) case (a)
            5'h00: m_base[0] = {wd[31:2], 2'b00};
            5'h04: m_base[1] = {wd[31:2], 2'b00};
            5'h08: m_len[0]  = {6'b0, wd[25:2], 2'b00};
            5'h0C: m_len[1]  = {6'b0, wd[25:2], 2'b00};
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit k0, input bit k1);
        for (int i = 0; i < n; i++) step(0, 5'(($urandom % 8) * 4), 0, k0, k1);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step(1, a, d, 0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nfail++; nchk++;
                $display("FAIL watchdog act=%0d exp=<150000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A1D));
        for (int i = 0; i < 2; i++) begin
            m_act[i] = 0; m_half[i] = 0; m_full[i] = 0; m_auto[i] = 0;
            m_addr[i] = 0; m_cnt[i] = 0; m_base[i] = 0; m_len[i] = 0; m_align[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every offset reads zero after reset
        tag = "R1";
        for (int a = 0; a < 32; a += 4) step(0, 5'(a), 0, 0, 0);

        // R2: alignment masking and largest length
        tag = "R2";
        wr(5'h00, 32'h1234_5677); wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h08, 32'hFFFF_FFFF); wr(5'h0C, 32'h0000_000B);
        for (int a = 0; a < 32; a += 4) step(0, 5'(a), 0, 0, 0);
        chk(m_len[0] == 32'h03FF_FFFC, "R2 max length", m_len[0], 32'h03FF_FFFC);

        // R3: control fields; stop bits read as zero
        tag = "R3";
        wr(5'h10, 32'h0206_0106);
        step(0, 5'h10, 0, 0, 0);
        wr(5'h10, 32'h0);

        // R4 R6 R7 R9: one tx pass of 16 bytes, no auto-reload
        tag = "R9";
        wr(5'h00, 32'h0000_1000); wr(5'h08, 32'd16);
        wr(5'h10, 32'h0000_0001);
        step(0, 5'h14, 0, 0, 0);
        idle(8, 1, 0);

        // R8: rx auto-reload, minimum 8-byte ring
        tag = "R8";
        wr(5'h04, 32'h0000_2000); wr(5'h0C, 32'd8);
        wr(5'h10, 32'h0005_0000);
        idle(12, 0, 1);

        // R5: tx with irregular acknowledge, rx still running (R11)
        tag = "R5";
        wr(5'h08, 32'd24); wr(5'h10, 32'h0005_0005);
        for (int i = 0; i < 40; i++) step(0, 5'h14, 0, ($urandom % 3) == 0, 0);

        // R10: stop with enable in the same write and an ack on the same edge
        tag = "R10";
        step(1, 5'h10, 32'h0000_0003, 1, 1);
        step(0, 5'h10, 0, 1, 1);
        step(0, 5'h14, 0, 1, 1);
        wr(5'h10, 32'h0002_0000);
        step(0, 5'h18, 0, 1, 1);

        // R12: re-enable while running does not restart
        tag = "R12";
        wr(5'h08, 32'd40); wr(5'h10, 32'h0000_0005);
        idle(3, 1, 0);
        wr(5'h10, 32'h0000_0005);
        step(0, 5'h14, 0, 1, 0);
        chk(m_cnt[0] == 32'd16, "R12 progress kept", m_cnt[0], 32'd16);
        wr(5'h10, 32'h0002_0002);

        // R11: both directions random
        tag = "R11";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 100;
            if (r < 2) begin
                logic [31:0] c = 0;
                for (int d = 0; d < 2; d++) begin
                    c[d*16]        = ($urandom % 2);
                    c[d*16+1]      = (($urandom % 8) == 0);
                    c[d*16+2]      = ($urandom % 2);
                    c[d*16+8 +: 2] = 2'($urandom % 3);
                end
                wr(5'h10, c);
            end else if (r < 4) begin
                wr(5'(($urandom % 2) * 4), $urandom);
            end else if (r < 6) begin
                wr(5'(8 + ($urandom % 2) * 4), 32'(8 + ($urandom % 15) * 4));
            end else begin
                step(0, 5'(($urandom % 8) * 4), 0, ($urandom % 4) != 0, ($urandom % 3) != 0);
            end
        end
        wr(5'h10, 32'h0002_0002);
        idle(2, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule